// File: doc/BRIEF.md
# Addressed SPI Command Engine for a Six-Channel Switch Controller

This block is the digital front end of a six-channel output controller. A host talks to it with 16-bit SPI frames. Each frame is a control byte followed by a data byte, sent MSB first. The block samples SCLK, SI and chip select with its own system clock. It accepts a frame only if the frame's two leading bits carry its address. It decodes the command and keeps two 6-bit registers:

- a mode register, which picks for each channel between serial control and the parallel input pin;
- a serial-state register, which holds the on/off request used under serial control.

The serial output returns diagnostic data captured from an external fault register, or reads back either register. The serial output has a separate output-enable, so several devices can share one bus. A valid diagnostics-read frame produces a single-cycle clear strobe for the fault register. The final per-channel on/off controls are resolved from the two registers, the parallel input pins and a polarity-select pin.

Timing assumptions:

- The system clock runs at least four times faster than SCLK.
- SCLK idles low and is low whenever chip select changes.

Top module: `spi_cmd_engine`

## Requirements
- R1: A frame whose first two SI bits are not 1 then 0 keeps `spi_miso_oe` low for the whole frame. It writes no register and issues no clear.
- R2: In an addressed frame, SI is sampled on SCLK falling edges. `spi_miso_oe` stays low through the first two SCLK rising edges. From the third rising edge on, each rising edge puts the next frame bit on `spi_miso`, MSB first.
- R3: SO frame bits 13 and 12 carry the common-fault and over-temperature inputs. Bits 11..10 carry channel 6's 2-bit diagnostic and bits 9..8 carry channel 5's.
- R4: Control bits 7..2 select the content of SO bits 7..0:
  - 100101 returns serial-state bits ch6..ch1 followed by 11.
  - 101001 returns mode bits ch6..ch1 followed by 11.
  - Any other code returns the diagnostics of ch4, ch3, ch2 and ch1, 2 bits each, in that order from bit 7 down.
- R5: Control code 100110 writes the serial-state register and 101010 writes the mode register. The new value is data bits 7..2, mapped to ch6..ch1. The write takes effect when chip select rises.
- R6: A frame with other than exactly 16 SCLK falling edges while selected writes nothing and issues no clear.
- R7: A valid frame with code 100000 gives exactly one single-cycle `diag_clr` pulse after chip select rises. No other frame pulses it.
- R8: A code outside the five defined ones writes no register. It still returns the full diagnostics on SO.
- R9: SO diagnostic content is captured when chip select falls. Changes to the diagnostic inputs later in the frame do not alter it.
- R10: Reset sets both registers to all ones (a read-back returns FFh), drives `spi_miso_oe` low and forces `ch_on` to zero.
- R11: A channel whose mode bit is 0 is on exactly when its serial-state bit is 0.
- R12: A channel whose mode bit is 1 follows its parallel input. It is on when the input is high while `par_pol_hi` is 1, and on when the input is low while `par_pol_hi` is 0.
- R13: While chip select is high, SCLK and SI activity changes nothing and `spi_miso_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | SPI serial clock from the host |
| spi_mosi | input | 1 | SPI serial data in |
| spi_csn | input | 1 | SPI chip select, active low |
| spi_miso | output | 1 | SPI serial data out (valid when enabled) |
| spi_miso_oe | output | 1 | Output-enable for the serial data out driver |
| par_in | input | 6 | Parallel control inputs, bit 5 = channel 6 |
| par_pol_hi | input | 1 | 1: parallel inputs active high, 0: active low |
| diag_flt | input | 1 | Common fault flag from the fault register |
| diag_ot | input | 1 | Common over-temperature flag |
| diag_ch | input | 12 | Per-channel 2-bit diagnostics, [11:10] = channel 6, [1:0] = channel 1 |
| diag_clr | output | 1 | Single-cycle clear strobe for the fault register |
| ch_on | output | 6 | Resolved channel on controls, bit 5 = channel 6 |

## Verification
The bench counts frames of 15 and 17 edges as well as 16. A design that commits on a count of at least 16, or at any count, would change a register or pulse the clear strobe on those frames.

Frames with foreign address bits and frames with unused codes are sent and then read back. An engine that drove SO before checking the address, or that treated an unknown code as a write, shows up either on the output-enable or in the read-back value.

The bench flips the diagnostic inputs in the middle of a frame. It also toggles SCLK and SI with chip select high. A design that reads diagnostics live, or shifts without being selected, returns the wrong bits or corrupts a register.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

    localparam int NCH        = 6;
    localparam int DIAG_W     = 2 * NCH;
    localparam int FRAME_BITS = 16;
    localparam int CNT_W      = $clog2(FRAME_BITS + 2);
    localparam int ADDR_BITS  = 2;
    localparam int CMD_W      = 6;

    typedef enum logic [CMD_W-1:0] {
        CMD_WR_SER  = 6'b100110,
        CMD_RD_SER  = 6'b100101,
        CMD_WR_MODE = 6'b101010,
        CMD_RD_MODE = 6'b101001,
        CMD_RD_DIAG = 6'b100000
    } cmd_e;

    typedef enum logic [1:0] {
        ADDR_WAIT = 2'd0,
        ADDR_OK   = 2'd1,
        ADDR_REJ  = 2'd2
    } addr_e;

    typedef struct packed {
        logic           wr_ser;
        logic           wr_mode;
        logic           clr;
        logic [NCH-1:0] data;
    } commit_t;

    typedef struct packed {
        logic              flt;
        logic              ot;
        logic [DIAG_W-1:0] ch;
    } diag_t;

    // Content of the second returned byte for a decoded command.
    function automatic logic [7:0] pick_second(
        input logic [CMD_W-1:0] cmd,
        input logic [NCH-1:0]   ser,
        input logic [NCH-1:0]   mode,
        input logic [7:0]       low_diag
    );
        if (cmd == CMD_RD_SER)       return {ser, 2'b11};
        else if (cmd == CMD_RD_MODE) return {mode, 2'b11};
        else                         return low_diag;
    endfunction

endpackage

// File: rtl/spi_cmd_sync.sv
module spi_cmd_sync #(
    parameter int               WIDTH   = 3,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_cmd_frame.sv
module spi_cmd_frame
    import spi_cmd_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                sclk_s,
    input  logic                mosi_s,
    input  logic                csn_s,
    input  diag_t               diag_in,
    input  logic [NCH-1:0]      ser_q,
    input  logic [NCH-1:0]      mode_q,
    output logic                miso,
    output logic                miso_oe,
    output commit_t             commit,
    output logic [CNT_W-1:0]    fall_cnt,
    output logic [CNT_W-1:0]    rise_cnt
);
    localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_BITS + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);

    logic                  sclk_d, csn_d;
    logic                  sclk_fall, sclk_rise, cs_fall, cs_rise;
    logic [FRAME_BITS-1:0] rx_sh;
    logic [CMD_W-1:0]      cmd_q;
    addr_e                 addr_st;
    diag_t                 snap;
    logic                  miso_q, oe_q;
    logic [CNT_W-1:0]      rise_nxt, pos_full;
    logic [FRAME_BITS-1:0] tx_word;
    logic                  tx_bit;

    assign sclk_fall = sclk_d & ~sclk_s;
    assign sclk_rise = ~sclk_d & sclk_s;
    assign cs_fall   = csn_d & ~csn_s;
    assign cs_rise   = ~csn_d & csn_s;

    assign rise_nxt = (rise_cnt < CNT_FULL) ? rise_cnt + CNT_W'(1) : rise_cnt;
    assign pos_full = CNT_FULL - rise_nxt;

    assign tx_word = {2'b11, snap.flt, snap.ot, snap.ch[DIAG_W-1 -: 4],
                      pick_second(cmd_q, ser_q, mode_q, snap.ch[7:0])};

    always_comb begin
        tx_bit = 1'b0;
        for (int i = 0; i < FRAME_BITS; i++)
            if (pos_full == CNT_W'(i)) tx_bit = tx_word[i];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_d   <= 1'b0;
            csn_d    <= 1'b1;
            fall_cnt <= '0;
            rise_cnt <= '0;
            rx_sh    <= '0;
            cmd_q    <= '0;
            addr_st  <= ADDR_WAIT;
            snap     <= '1;
            miso_q   <= 1'b0;
            oe_q     <= 1'b0;
        end else begin
            sclk_d <= sclk_s;
            csn_d  <= csn_s;
            if (cs_fall) begin
                fall_cnt <= '0;
                rise_cnt <= '0;
                rx_sh    <= '0;
                cmd_q    <= '0;
                addr_st  <= ADDR_WAIT;
                snap     <= diag_in;
                miso_q   <= 1'b0;
                oe_q     <= 1'b0;
            end else if (csn_s) begin
                miso_q <= 1'b0;
                oe_q   <= 1'b0;
            end else begin
                if (sclk_fall) begin
                    rx_sh <= {rx_sh[FRAME_BITS-2:0], mosi_s};
                    if (fall_cnt != CNT_SAT) fall_cnt <= fall_cnt + CNT_W'(1);
                    if (fall_cnt == CNT_W'(ADDR_BITS - 1))
                        addr_st <= (rx_sh[0] && !mosi_s) ? ADDR_OK : ADDR_REJ;
                    if (fall_cnt == CNT_W'(7))
                        cmd_q <= rx_sh[6:1];
                end
                if (sclk_rise) begin
                    rise_cnt <= rise_nxt;
                    miso_q   <= tx_bit;
                    oe_q     <= (addr_st == ADDR_OK) && (rise_nxt > CNT_W'(ADDR_BITS));
                end
            end
        end
    end

    always_comb begin
        commit      = '0;
        commit.data = rx_sh[7:2];
        if (cs_rise && fall_cnt == CNT_FULL) begin
            case (rx_sh[FRAME_BITS-1 -: CMD_W])
                CMD_WR_SER:  commit.wr_ser  = 1'b1;
                CMD_WR_MODE: commit.wr_mode = 1'b1;
                CMD_RD_DIAG: commit.clr     = 1'b1;
                default:     ;
            endcase
        end
    end

    assign miso    = oe_q & miso_q;
    assign miso_oe = oe_q;
endmodule

// File: rtl/spi_cmd_regs.sv
module spi_cmd_regs
    import spi_cmd_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  commit_t        commit,
    input  logic [NCH-1:0] par_in,
    input  logic           par_pol_hi,
    output logic [NCH-1:0] ser_q,
    output logic [NCH-1:0] mode_q,
    output logic [NCH-1:0] ch_on,
    output logic           diag_clr
);
    logic [NCH-1:0] want;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic par_act;
        assign par_act = par_in[c] ~^ par_pol_hi;
        assign want[c] = mode_q[c] ? par_act : ~ser_q[c];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ser_q    <= '1;
            mode_q   <= '1;
            ch_on    <= '0;
            diag_clr <= 1'b0;
        end else begin
            if (commit.wr_ser)  ser_q  <= commit.data;
            if (commit.wr_mode) mode_q <= commit.data;
            diag_clr <= commit.clr;
            ch_on    <= want;
        end
    end
endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
    import spi_cmd_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              spi_sclk,
    input  logic              spi_mosi,
    input  logic              spi_csn,
    output logic              spi_miso,
    output logic              spi_miso_oe,
    input  logic [NCH-1:0]    par_in,
    input  logic              par_pol_hi,
    input  logic              diag_flt,
    input  logic              diag_ot,
    input  logic [DIAG_W-1:0] diag_ch,
    output logic              diag_clr,
    output logic [NCH-1:0]    ch_on
);
    logic             csn_s, sclk_s, mosi_s;
    logic [NCH-1:0]   ser_q, mode_q;
    commit_t          commit;
    diag_t            diag_bus;
    logic [CNT_W-1:0] fall_cnt, rise_cnt;
    logic             wr_any;

    assign diag_bus = '{flt: diag_flt, ot: diag_ot, ch: diag_ch};
    assign wr_any   = commit.wr_ser | commit.wr_mode;

    spi_cmd_sync #(
        .WIDTH  (3),
        .STAGES (SYNC_STAGES),
        .RST_VAL(3'b100)
    ) u_sync (
        .clk(clk),
        .rst(rst),
        .d  ({spi_csn, spi_sclk, spi_mosi}),
        .q  ({csn_s, sclk_s, mosi_s})
    );

    spi_cmd_frame u_frame (
        .clk     (clk),
        .rst     (rst),
        .sclk_s  (sclk_s),
        .mosi_s  (mosi_s),
        .csn_s   (csn_s),
        .diag_in (diag_bus),
        .ser_q   (ser_q),
        .mode_q  (mode_q),
        .miso    (spi_miso),
        .miso_oe (spi_miso_oe),
        .commit  (commit),
        .fall_cnt(fall_cnt),
        .rise_cnt(rise_cnt)
    );

    spi_cmd_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .commit    (commit),
        .par_in    (par_in),
        .par_pol_hi(par_pol_hi),
        .ser_q     (ser_q),
        .mode_q    (mode_q),
        .ch_on     (ch_on),
        .diag_clr  (diag_clr)
    );
endmodule

// File: rtl/spi_cmd_engine_chk.sv
module spi_cmd_engine_chk
    import spi_cmd_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             csn_s,
    input logic             miso_oe,
    input logic             diag_clr,
    input logic [NCH-1:0]   ch_on,
    input logic [NCH-1:0]   ser_q,
    input logic [NCH-1:0]   mode_q,
    input logic             wr_any,
    input logic [CNT_W-1:0] fall_cnt,
    input logic [CNT_W-1:0] rise_cnt
);
    AST_CLR_SINGLE: assert property (@(posedge clk) disable iff (rst) diag_clr |=> !diag_clr); // R7
    AST_CLR_FULL_FRAME: assert property (@(posedge clk) disable iff (rst) diag_clr |-> fall_cnt == CNT_W'(FRAME_BITS)); // R6
    AST_OE_AFTER_ADDR: assert property (@(posedge clk) disable iff (rst) miso_oe |-> rise_cnt > CNT_W'(ADDR_BITS)); // R2
    AST_OE_DESELECT: assert property (@(posedge clk) disable iff (rst) csn_s |=> !miso_oe); // R13
    AST_REGS_HOLD: assert property (@(posedge clk) disable iff (rst) !wr_any |=> ($stable(ser_q) && $stable(mode_q))); // R5
    AST_RST_OFF: assert property (@(posedge clk) disable iff (rst) $fell(rst) |-> (ch_on == '0 && !miso_oe)); // R10
endmodule

bind spi_cmd_engine spi_cmd_engine_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .csn_s   (csn_s),
    .miso_oe (spi_miso_oe),
    .diag_clr(diag_clr),
    .ch_on   (ch_on),
    .ser_q   (ser_q),
    .mode_q  (mode_q),
    .wr_any  (wr_any),
    .fall_cnt(fall_cnt),
    .rise_cnt(rise_cnt)
);

// File: tb/tb_spi_cmd_engine.sv
module tb_spi_cmd_engine;
    localparam int HALF = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sclk = 1'b0, mosi = 1'b0, csn = 1'b1;
    logic [5:0]  par_in = 6'b101010;
    logic        pol_hi = 1'b1;
    logic        diag_flt = 1'b1, diag_ot = 1'b0;
    logic [11:0] diag_ch = 12'b11_10_01_00_11_01;
    logic        miso, miso_oe, diag_clr;
    logic [5:0]  ch_on;

    int    checks = 0, errors = 0, clr_seen = 0, clr_exp = 0;
    bit    done = 0;
    string cur_req = "R3";
    logic [1:0] exp_q[$];
    logic [5:0] ser_m = 6'h3F, mode_m = 6'h3F;

    spi_cmd_engine dut (
        .clk(clk), .rst(rst), .spi_sclk(sclk), .spi_mosi(mosi), .spi_csn(csn),
        .spi_miso(miso), .spi_miso_oe(miso_oe), .par_in(par_in), .par_pol_hi(pol_hi),
        .diag_flt(diag_flt), .diag_ot(diag_ot), .diag_ch(diag_ch),
        .diag_clr(diag_clr), .ch_on(ch_on)
    );

    always #10 clk = ~clk;

    always @(posedge clk) if (!rst && diag_clr) clr_seen++;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    // Monitor: pops one expected SO item per selected SCLK falling edge.
    always @(negedge sclk) begin
        logic [1:0] e;
        if (!csn) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL %s SO act=unexpected edge exp=none", cur_req);
            end else begin
                e = exp_q.pop_front();
                if (miso_oe !== e[1] || (e[1] && miso !== e[0])) begin
                    errors++;
                    $display("FAIL %s SO act oe=%b d=%b exp oe=%b d=%b",
                             cur_req, miso_oe, miso, e[1], e[0]);
                end
            end
        end
    end

    function automatic logic [15:0] so_word(input logic [7:0] ctl);
        logic [7:0] b2;
        case (ctl[7:2])
            6'b100101: b2 = {ser_m, 2'b11};
            6'b101001: b2 = {mode_m, 2'b11};
            default:   b2 = diag_ch[7:0];
        endcase
        return {2'b11, diag_flt, diag_ot, diag_ch[11:8], b2};
    endfunction

    function automatic logic [5:0] ch_model();
        return (mode_m & ~(par_in ^ {6{pol_hi}})) | (~mode_m & ~ser_m);
    endfunction

    // Driver: pushes the expected SO stream, then drives the frame.
    task automatic frame(input logic [7:0] ctl, input logic [7:0] dat,
                         input int nbits, input string req, input bit flip);
        logic [15:0] w = {ctl, dat};
        logic [15:0] e = so_word(ctl);
        bit addr_ok = (ctl[7:6] == 2'b10);
        cur_req = req;
        for (int k = 1; k <= nbits; k++) begin
            int p = (k <= 16) ? 16 - k : 0;
            exp_q.push_back({addr_ok && k >= 3, e[p]});
        end
        @(negedge clk);
        csn = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int k = 1; k <= nbits; k++) begin
            mosi = (k <= 16) ? w[16-k] : 1'b0;
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            sclk = 1'b0;
            repeat (HALF) @(negedge clk);
            if (flip && k == 4) begin
                diag_ch  = ~diag_ch;
                diag_flt = ~diag_flt;
            end
        end
        repeat (HALF) @(negedge clk);
        csn = 1'b1;
        repeat (3 * HALF) @(negedge clk);
        if (nbits == 16) begin
            case (ctl[7:2])
                6'b100110: ser_m  = dat[7:2];
                6'b101010: mode_m = dat[7:2];
                6'b100000: clr_exp++;
                default: ;
            endcase
        end
        check({req, " SO items consumed"}, exp_q.size(), 0);
        check({req, " clear pulses"}, clr_seen, clr_exp);
        check({req, " ch_on"}, ch_on, ch_model());
    endtask

    task automatic noise_deselected();
        for (int k = 0; k < 16; k++) begin
            mosi = k[0];
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            sclk = 1'b0;
            repeat (HALF) @(negedge clk);
        end
        repeat (2 * HALF) @(negedge clk);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        check("R10 reset ch_on", ch_on, 0);
        check("R10 reset oe", miso_oe, 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check("R12 parallel after reset", ch_on, 6'b101010);

        frame(8'h94, 8'h00, 16, "R10", 0);          // read serial-state: FFh
        frame(8'hA4, 8'h00, 16, "R10", 0);          // read mode: FFh
        frame(8'h98, 8'h58, 16, "R3", 0);           // write serial-state 010110
        frame(8'hA8, 8'h00, 16, "R11", 0);          // all channels serial
        frame(8'hA4, 8'hFF, 16, "R4", 0);           // read mode back
        frame(8'h94, 8'hFF, 16, "R4", 0);           // read serial-state back
        frame(8'hA8, 8'hC0, 16, "R5", 0);           // ch6, ch5 parallel
        pol_hi = 1'b0;
        par_in = 6'b100000;
        repeat (3) @(negedge clk);
        check("R12 low-active parallel", ch_on, ch_model());
        par_in = 6'b010000;
        repeat (3) @(negedge clk);
        check("R12 low-active parallel swap", ch_on, ch_model());

        frame(8'h80, 8'h00, 16, "R7", 0);           // valid diagnostics read
        frame(8'h94, 8'h00, 16, "R7", 0);           // no clear on other reads
        frame(8'h98, 8'hFC, 15, "R6", 0);
        frame(8'h98, 8'hFC, 17, "R6", 0);
        frame(8'h80, 8'h00, 15, "R6", 0);
        frame(8'h80, 8'h00, 17, "R6", 0);
        frame(8'h94, 8'h00, 16, "R6", 0);           // serial-state unchanged

        frame(8'h58, 8'h00, 16, "R1", 0);           // wrong address 01
        frame(8'hE8, 8'h00, 16, "R1", 0);           // wrong address 11
        frame(8'hA4, 8'h00, 16, "R1", 0);           // mode unchanged

        frame(8'hB4, 8'hFC, 16, "R8", 0);           // unused code 101101
        frame(8'h84, 8'h00, 16, "R8", 0);           // unused code 100001
        frame(8'h94, 8'h00, 16, "R8", 0);
        frame(8'hA4, 8'h00, 16, "R8", 0);

        frame(8'h80, 8'h00, 16, "R9", 1);           // diag flips mid-frame
        frame(8'h88, 8'h00, 16, "R9", 0);           // flipped values now visible

        noise_deselected();
        check("R13 oe while deselected", miso_oe, 0);
        check("R13 clear pulses", clr_seen, clr_exp);
        frame(8'h94, 8'h00, 16, "R13", 0);
        frame(8'hA4, 8'h00, 16, "R13", 0);
        frame(8'h98, 8'h3C, 16, "R2", 0);           // write then read
        frame(8'h94, 8'h00, 16, "R2", 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog act=running exp=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule